// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI master from its module clock. A single divider word holds two divisor fields and a law-select bit. With the bit set, the serial clock period is 2×(N+1) module clocks. With the bit clear, the period is 2^M module clocks. Alongside the serial clock level, the block produces a one-cycle leading-edge pulse and a one-cycle trailing-edge pulse. The shift engine uses these pulses to launch and capture data.

The divider word, the law and the clock polarity are sampled only while the run input is low. A transfer therefore always uses the settings that stood before it started. When run drops, the clock returns to its idle level and the count restarts from zero. In the power-of-two law with M = 0, the serial clock would run at the module clock rate. In that case the block holds the clock level flat and raises both edge pulses on every running cycle, so they serve as plain enable strobes.

Top module: `spi_clk_div`

## Requirements
- R1: While rst_ni is low, sclk_o, lead_o and trail_o are all 0.
- R2: At each clock edge with run_i low, the block clears its count, drives sclk_o to the value cpol_i had at that edge and drives lead_o and trail_o to 0.
- R3: With div_cfg_i bit 12 set, let N be bits 7:0. The serial clock spends N+1 module cycles at each level, giving a period of 2×(N+1).
- R4: With bit 12 clear, let M be bits 11:8, with M ≥ 1. The serial clock spends 2^(M-1) module cycles at each level, giving a period of 2^M. In this law the bits 7:0 are ignored.
- R5: Let H be the half period and call the first rising clk_i edge with run_i high edge 1. sclk_o first leaves its idle level right after edge H. It then toggles after every further H edges.
- R6: lead_o is high for exactly the one cycle in which sclk_o has just left its idle level. trail_o is high for exactly the one cycle in which sclk_o has just returned to its idle level.
- R7: In power-of-two mode with M = 0, while running, sclk_o stays at the idle level and lead_o and trail_o are both high on every cycle after edge 1.
- R8: Changes to div_cfg_i or cpol_i while run_i is high do not affect the running clock. They apply from the next run after an idle edge.
- R9: With cpol_i = 1, the idle level is high and the leading edge is a falling edge.
- R10: Dropping run_i in mid-period returns the clock to idle at the next edge. The next run starts a fresh count, as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | High while a transfer runs |
| cpol_i | input | 1 | Idle level of the serial clock |
| div_cfg_i | input | LIN_W+EXP_W+1 | Divider word: N in [LIN_W-1:0], M in [LIN_W+EXP_W-1:LIN_W], law select in the top bit |
| sclk_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle pulse when the clock has just left idle |
| trail_o | output | 1 | One-cycle pulse when the clock has just returned to idle |

## Verification
The bench builds the block with LIN_W = 4 and EXP_W = 3. This shrinks the divider word to 8 bits and the largest half period to 64 cycles. At that size it is practical to sweep every linear divisor from 0 to 15 and every exponent from 0 to 7 under both polarities. Each sweep point runs for two full serial periods, and every cycle is checked against the expected level and pulses computed from the edge index. Separate runs change the divider word in mid-transfer and stop a transfer in mid-period, to check that settings are held and that the count restarts.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;

  typedef enum logic {
    PH_REST   = 1'b0,
    PH_ACTIVE = 1'b1
  } sclk_phase_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_div_cfg.sv
module spi_div_cfg #(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4,
  parameter int unsigned CNT_W = 14
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         run_i,
  input  logic                         cpol_i,
  input  logic [LIN_W+EXP_W:0]         div_cfg_i,
  output logic [CNT_W-1:0]             term_o,
  output logic                         bypass_o,
  output logic                         pol_o
);
  localparam int unsigned MODE_BIT = LIN_W + EXP_W;

  logic [LIN_W-1:0] lin_n;
  logic [EXP_W-1:0] exp_m;
  logic             lin_mode;
  logic [CNT_W-1:0] term_d, term_q;
  logic             bypass_d, bypass_q, pol_q;

  assign lin_n    = div_cfg_i[LIN_W-1:0];
  assign exp_m    = div_cfg_i[LIN_W +: EXP_W];
  assign lin_mode = div_cfg_i[MODE_BIT];

  // terminal count = half period - 1
  always_comb begin
    term_d   = '0;
    bypass_d = 1'b0;
    if (lin_mode) begin
      term_d = CNT_W'(lin_n);
    end else if (exp_m == '0) begin
      bypass_d = 1'b1;
    end else begin
      term_d = (CNT_W'(1) << (exp_m - EXP_W'(1))) - CNT_W'(1);
    end
  end

  // settings only move while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_q   <= '0;
      bypass_q <= 1'b0;
      pol_q    <= 1'b0;
    end else if (!run_i) begin
      term_q   <= term_d;
      bypass_q <= bypass_d;
      pol_q    <= cpol_i;
    end
  end

  assign term_o   = term_q;
  assign bypass_o = bypass_q;
  assign pol_o    = pol_q;

  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_i) |-> ($stable(term_q) && $stable(bypass_q) && $stable(pol_q)));

endmodule

// File: rtl/spi_div_count.sv
module spi_div_count #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= term_i));

  assert_cnt_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/spi_div_phase.sv
module spi_div_phase
  import spi_clk_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic bypass_i,
  output logic phase_o,
  output logic lead_o,
  output logic trail_o
);
  sclk_phase_e phase_q;
  logic        lead_q, trail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_REST;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!run_i) begin
      phase_q <= PH_REST;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (bypass_i) begin
      phase_q <= PH_REST;
      lead_q  <= 1'b1;
      trail_q <= 1'b1;
    end else if (tick_i) begin
      phase_q <= (phase_q == PH_REST) ? PH_ACTIVE : PH_REST;
      lead_q  <= (phase_q == PH_REST);
      trail_q <= (phase_q == PH_ACTIVE);
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end
  end

  assign phase_o = phase_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

  assert_edge_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_q && !bypass_i) |-> !trail_q);

  assert_lead_active_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_q && !bypass_i) |-> (phase_q == PH_ACTIVE));

endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_clk_div_pkg::*;
#(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic                 cpol_i,
  input  logic [LIN_W+EXP_W:0] div_cfg_i,
  output logic                 sclk_o,
  output logic                 lead_o,
  output logic                 trail_o
);
  // half period: linear up to 2^LIN_W, power-of-two up to 2^(2^EXP_W-2)
  localparam int unsigned CNT_W = max_u(max_u(LIN_W, (1 << EXP_W) - 2), 1);

  logic [CNT_W-1:0] term;
  logic             bypass, pol, tick, phase;

  spi_div_cfg #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i, .rst_ni, .run_i, .cpol_i, .div_cfg_i,
    .term_o(term), .bypass_o(bypass), .pol_o(pol)
  );

  spi_div_count #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i, .term_i(term), .tick_o(tick)
  );

  spi_div_phase u_phase (
    .clk_i, .rst_ni, .run_i, .tick_i(tick), .bypass_i(bypass),
    .phase_o(phase), .lead_o, .trail_o
  );

  assign sclk_o = pol ^ phase;

  assert_idle_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ((sclk_o == $past(cpol_i)) && !lead_o && !trail_o));

  assert_sclk_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && !$stable(sclk_o)) |-> (lead_o || trail_o));

  assert_bypass_flat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && bypass) |-> (lead_o && trail_o && (sclk_o == pol)));

endmodule

// File: tb/spi_clk_div_tb.sv
module spi_clk_div_tb;
  localparam int LW = 4;
  localparam int EW = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          run_i = 1'b0;
  logic          cpol_i = 1'b0;
  logic [LW+EW:0] div_cfg_i = '0;
  logic          sclk_o, lead_o, trail_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_clk_div #(.LIN_W(LW), .EXP_W(EW)) u_dut (
    .clk_i(clk), .rst_ni, .run_i, .cpol_i, .div_cfg_i,
    .sclk_o, .lead_o, .trail_o
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s {sclk,lead,trail} act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  // idle with new settings; checks the idle state after one idle edge (R2)
  task automatic go_idle(input logic [LW+EW:0] cfg, input logic pol);
    @(negedge clk);
    run_i = 1'b0;
    div_cfg_i = cfg;
    cpol_i = pol;
    @(negedge clk);
    chk("R2", {sclk_o, lead_o, trail_o}, {pol, 2'b00});
  endtask

  // checks edges j0..j0+n-1 of a run with half period h
  task automatic watch(input string req, input int h, input bit byp, input logic pol,
                       input int j0, input int n);
    for (int j = j0; j < j0 + n; j++) begin
      logic es, el, et;
      @(posedge clk);
      @(negedge clk);
      if (byp) begin
        es = pol; el = 1'b1; et = 1'b1;
      end else begin
        es = pol ^ logic'((j / h) % 2);
        el = (j % h == 0) && ((j / h) % 2 == 1);
        et = (j % h == 0) && ((j / h) % 2 == 0);
      end
      chk(req, {sclk_o, lead_o, trail_o}, {es, el, et});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {sclk_o, lead_o, trail_o}, 3'b000);
    rst_ni = 1'b1;

    // R2 / R9: idle level follows polarity
    go_idle('0, 1'b1);
    go_idle('0, 1'b0);

    // R3 R5 R6 R9: linear law sweep, bit 7 of this 8-bit word is the law select
    for (int p = 0; p < 2; p++) begin
      for (int n = 0; n < 16; n++) begin
        go_idle({1'b1, 3'd5, 4'(n)}, logic'(p));
        run_i = 1'b1;
        watch(p ? "R3 R9" : "R3 R5 R6", n + 1, 1'b0, logic'(p), 1, 4 * (n + 1) + 1);
      end
    end

    // R4 R5 R6 R9: power-of-two law, low field filled with junk
    for (int p = 0; p < 2; p++) begin
      for (int m = 1; m < 8; m++) begin
        go_idle({1'b0, 3'(m), 4'b1010}, logic'(p));
        run_i = 1'b1;
        watch(p ? "R4 R9" : "R4 R5 R6", 1 << (m - 1), 1'b0, logic'(p), 1, (1 << (m + 1)) + 1);
      end
    end

    // R7: M = 0 strobes
    for (int p = 0; p < 2; p++) begin
      go_idle({1'b0, 3'd0, 4'b0111}, logic'(p));
      run_i = 1'b1;
      watch("R7", 1, 1'b1, logic'(p), 1, 6);
    end

    // R8: mid-run change ignored
    go_idle({1'b1, 3'd0, 4'd2}, 1'b0);
    run_i = 1'b1;
    watch("R8", 3, 1'b0, 1'b0, 1, 7);
    div_cfg_i = {1'b1, 3'd0, 4'd5};
    cpol_i = 1'b1;
    watch("R8", 3, 1'b0, 1'b0, 8, 10);

    // R10: stop mid-period, restart fresh with the new settings
    @(negedge clk);
    run_i = 1'b0;
    @(negedge clk);
    chk("R10", {sclk_o, lead_o, trail_o}, 3'b100);
    run_i = 1'b1;
    watch("R10 R8", 6, 1'b0, 1'b1, 1, 13);
    @(negedge clk);
    run_i = 1'b0;
    @(negedge clk);
    chk("R10", {sclk_o, lead_o, trail_o}, 3'b100);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule